// File: doc/BRIEF.md
# Transient Pulse Suppressor Filter

This block guards every bit of a result bus against short spurious pulses. Each bit reaches a small voter through two copies. The voter has one register. When the register holds 0, it loads the AND of the two copies. When it holds 1, it loads the OR of the two copies. So the voter changes state only when both copies agree on the new level, and a disturbance seen on only one copy leaves it unchanged.

An elaboration parameter selects where the second copy comes from. In delay mode, it is the primary bit passed through a shift register of `DELAY` stages. In dual mode, it comes from a separate input bus that a duplicated copy of the upstream logic drives. Every bit has its own voter and its own register.

The block samples continuously, one word per clock, and has no handshake. Values that flow in are never stalled, so there is nothing to apply back-pressure to. A synchronous active-high reset clears all state.

Top module: `tps_filter`

## Requirements
- R1: Each of the `WIDTH` bits is filtered on its own. Activity on one bit never changes any other bit of `dout`.
- R2: While a bit of `dout` is 0, it stays 0 in any cycle where its two copies disagree.
- R3: While a bit of `dout` is 1, it stays 1 in any cycle where its two copies disagree.
- R4: In delay mode (`MODE` = 0), the second copy is `din_a` delayed by `DELAY` clock edges. A high or low pulse on `din_a` that is sampled on `DELAY` or fewer consecutive edges never reaches `dout`.
- R5: In delay mode, a level first sampled on edge k and held for more than `DELAY` edges appears on `dout` right after edge k+`DELAY`. A pulse of L > `DELAY` edges is reproduced with the same length L.
- R6: In delay mode, `din_b` has no effect on `dout`.
- R7: In dual mode (`MODE` = 1), a bit of `dout` takes the common value right after the first edge at which `din_a` and `din_b` agree on it.
- R8: In dual mode, a bit whose copies disagree for any number of cycles keeps its last agreed value for that whole time.
- R9: A synchronous reset forces `dout` to 0 and clears the delay line. After reset is released with `din_a` held at 1, `dout` stays 0 through edge k+`DELAY`-1, where k is the first edge out of reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| din_a | input | WIDTH | Primary copy of the protected bus |
| din_b | input | WIDTH | Duplicate copy (dual mode only, ignored in delay mode) |
| dout | output | WIDTH | Filtered bus, one voter register per bit |

## Verification
The bench builds two instances with `WIDTH` = 8 and `DELAY` = 3: one in delay mode and one in dual mode. Both take the same stimulus. A delay of 3 lets the bench test the boundary directly: a 3-edge pulse must vanish, and a 4-edge pulse must come through intact and shifted by exactly three edges. The 3-edge window after reset also shows that the delay line was cleared. With 8 bits, the bench can put pulses on one lane and watch the other lanes for disturbance. The same random sequences also hold a dual-mode disagreement for as long as the bench chooses.

// File: rtl/tps_pkg.sv
package tps_pkg;
  typedef enum logic {
    TPS_DELAY = 1'b0,
    TPS_DUAL  = 1'b1
  } tps_mode_e;
endpackage

// File: rtl/tps_delay_line.sv
module tps_delay_line #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  localparam int LAST = DEPTH - 1;

  logic [WIDTH-1:0] stage [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst) stage[0] <= '0;
        else     stage[0] <= din;
      end
      AST_DLY_HEAD: assert property (@(posedge clk) disable iff (rst)
        !rst |=> stage[0] == $past(din)); // R4
    end else begin : g_tail
      always_ff @(posedge clk) begin
        if (rst) stage[i] <= '0;
        else     stage[i] <= stage[i-1];
      end
      AST_DLY_SHIFT: assert property (@(posedge clk) disable iff (rst)
        !rst |=> stage[i] == $past(stage[i-1])); // R4
    end
  end

  assign dout = stage[LAST];
endmodule

// File: rtl/tps_hold_voter.sv
module tps_hold_voter (
  input  logic clk,
  input  logic rst,
  input  logic copy_a,
  input  logic copy_b,
  output logic q
);
  logic both_hi;
  logic either_hi;
  logic q_next;

  assign both_hi   = copy_a & copy_b;
  assign either_hi = copy_a | copy_b;

  // selector steered by the voter's own registered output
  always_comb begin
    if (q) q_next = either_hi;
    else   q_next = both_hi;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= q_next;
  end

  AST_SET_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (!q && (copy_a != copy_b)) |=> !q); // R2
  AST_CLEAR_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (q && (copy_a != copy_b)) |=> q); // R3
  AST_AGREE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (copy_a && copy_b) |=> q); // R7
  AST_AGREE_LOW: assert property (@(posedge clk) disable iff (rst)
    (!copy_a && !copy_b) |=> !q); // R7
endmodule

// File: rtl/tps_filter.sv
module tps_filter #(
  parameter int                  WIDTH = 8,
  parameter int                  DELAY = 3,
  parameter tps_pkg::tps_mode_e  MODE  = tps_pkg::TPS_DELAY
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din_a,
  input  logic [WIDTH-1:0] din_b,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] second_copy;

  if (MODE == tps_pkg::TPS_DELAY) begin : g_delay
    logic unused_din_b;
    assign unused_din_b = ^din_b;
    tps_delay_line #(.WIDTH(WIDTH), .DEPTH(DELAY)) u_dly (
      .clk  (clk),
      .rst  (rst),
      .din  (din_a),
      .dout (second_copy)
    );
  end else begin : g_dual
    assign second_copy = din_b;
  end

  for (genvar b = 0; b < WIDTH; b++) begin : g_lane
    tps_hold_voter u_vote (
      .clk    (clk),
      .rst    (rst),
      .copy_a (din_a[b]),
      .copy_b (second_copy[b]),
      .q      (dout[b])
    );
  end
endmodule

// File: tb/sim_tps_filter.sv
`timescale 1ns/1ps
module sim_tps_filter;
  import tps_pkg::*;
  localparam int W = 8;
  localparam int D = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] da = '1;
  logic [W-1:0] db = '1;
  logic [W-1:0] q_dly, q_dual;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tps_filter #(.WIDTH(W), .DELAY(D), .MODE(TPS_DELAY)) u0 (
    .clk(clk), .rst(rst), .din_a(da), .din_b(db), .dout(q_dly));
  tps_filter #(.WIDTH(W), .DELAY(D), .MODE(TPS_DUAL)) u1 (
    .clk(clk), .rst(rst), .din_a(da), .din_b(db), .dout(q_dual));

  // expected-value model built from the voting rule
  logic [W-1:0] m_dly, m_dual;
  logic [W-1:0] hist [D];

  function automatic logic [W-1:0] vote(logic [W-1:0] q, logic [W-1:0] a, logic [W-1:0] b);
    return (q & (a | b)) | (~q & a & b);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_dly  <= '0;
      m_dual <= '0;
      for (int i = 0; i < D; i++) hist[i] <= '0;
    end else begin
      m_dly  <= vote(m_dly, da, hist[D-1]);
      m_dual <= vote(m_dual, da, db);
      hist[0] <= da;
      for (int i = 1; i < D; i++) hist[i] <= hist[i-1];
    end
  end

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    step(); step();
    chk("R9 reset dly", q_dly, '0);
    chk("R9 reset dual", q_dual, '0);
    rst = 1'b0;
    step();
    chk("R7 dual agree after reset", q_dual, 8'hFF);
    chk("R9 dly cleared k", q_dly, 8'h00);
    for (int s = 1; s < D; s++) begin
      step();
      chk("R9 dly cleared window", q_dly, 8'h00);
    end
    step();
    chk("R5 dly latency rise", q_dly, 8'hFF);

    // low pulse of D edges on bit 3
    da = 8'hF7;
    for (int s = 0; s < D; s++) step();
    da = 8'hFF;
    for (int s = 0; s < 2*D + 2; s++) begin
      chk("R4 low pulse blocked", q_dly, 8'hFF);
      chk("R3 dual one-copy dip", q_dual, 8'hFF);
      step();
    end

    da = 8'h00; db = 8'h00;
    step();
    chk("R7 dual fall", q_dual, 8'h00);
    for (int s = 1; s < D; s++) step();
    chk("R5 dly hold before fall", q_dly, 8'hFF);
    step();
    chk("R5 dly fall", q_dly, 8'h00);

    // high pulse of D edges on bit 0
    da = 8'h01;
    for (int s = 0; s < D; s++) step();
    da = 8'h00;
    for (int s = 0; s < 2*D + 2; s++) begin
      chk("R4 high pulse blocked", q_dly, 8'h00);
      chk("R2 dual one-copy glitch", q_dual, 8'h00);
      step();
    end

    // high pulse of D+1 edges on bit 1
    da = 8'h02;
    for (int s = 1; s <= 3*D + 2; s++) begin
      step();
      if (s == D + 1) da = 8'h00;
      chk("R5 long pulse reproduced", q_dly,
          (s > D && s <= 2*D + 1) ? 8'h02 : 8'h00);
      chk("R1 other lanes quiet", q_dly & 8'hFD, 8'h00);
    end

    // din_b toggling in delay mode
    da = 8'h00;
    for (int s = 0; s < 20; s++) begin
      db = W'($urandom);
      step();
      chk("R6 din_b ignored", q_dly, 8'h00);
      chk("R2 dual stays low", q_dual, 8'h00);
    end

    // persistent disagreement in dual mode
    da = 8'hFF; db = 8'hFF;
    step();
    chk("R7 dual rise", q_dual, 8'hFF);
    da = 8'h0F; db = 8'hF0;
    for (int s = 0; s < 30; s++) begin
      step();
      chk("R8 dual hold", q_dual, 8'hFF);
    end
    da = 8'h0F; db = 8'h0F;
    step();
    chk("R7 dual settle", q_dual, 8'h0F);
    for (int s = 0; s < D + 2; s++) step();

    // random phase with model comparison
    for (int n = 0; n < 3000; n++) begin
      logic [W-1:0] flip, glitch;
      flip   = W'($urandom) & W'($urandom) & W'($urandom);
      glitch = W'($urandom) & W'($urandom);
      da = da ^ flip;
      db = (n % 7 == 0) ? ~da : (da ^ glitch);
      step();
      chk("R1 R4 random dly", q_dly, m_dly);
      chk("R1 R8 random dual", q_dual, m_dual);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule